// File: doc/BRIEF.md
# Slow Peripheral Bus Cycle Sequencer

This block turns a single-cycle access request into a complete strobe sequence on a slow card-style peripheral bus. Each request names one of two address areas and a timing-set bit, giving four configuration slots. Each slot holds a base wait, a coarse extra wait, a setup code and a hold code. Each area also has its own idle-gap field. Once a request is accepted, the sequencer runs four phases in order. First it drives address-valid, chip select, the card enables and the register select without a strobe. Next it asserts the read or write strobe for the programmed wait length. Then it keeps the selects up after the strobe. Finally it stays busy with the bus released for the idle gap.

A three-bit attribute that comes with each request selects the space type and the data width. The attribute sets whether the upper card enable and the register-space select are driven for that access. A request with the reserved attribute starts no bus cycle and returns an error pulse. Read data from the bus is captured on the last cycle of the read strobe. A one-cycle done pulse marks the end of the hold phase.

Top module: `lsbus_cycle_ctrl`

## Requirements
- R1: Setup phase: for `S` cycles before the strobe rises, `bus_addr_vld`, `bus_cs` and `bus_ce_lo` are high, and neither strobe is high. `S` is looked up from the 3-bit setup code of the selected slot: codes 0..7 map to 0, 1, 2, 3, 4, 6, 8, 15 cycles.
- R2: Strobe length: the strobe stays high for `B + X + 1` consecutive cycles. `B` is the base wait of the selected slot. `X` comes from the 2-bit extra-wait code: 0→0, 1→15, 2→30, 3→50.
- R3: Hold phase: after the strobe falls, the selects stay high without a strobe for `H` cycles. `H` comes from the slot's hold code through the same table as R1.
- R4: Slot choice: the slot index is `{req_area, req_tset}`. A timing-set bit of 0 uses the first set of the area and 1 uses the second set.
- R5: Idle gap: after the hold phase, `busy` stays high for `cfg_idle[req_area]` more cycles with the bus released. The total busy length is `S + B + X + 1 + H + I`.
- R6: Width: `bus_ce_hi` follows `bus_cs` for 16-bit accesses and stays low for 8-bit accesses. Attribute codes 011, 101 and 111 are 16-bit, and so is 001 (dynamic sizing). Codes 010, 100 and 110 are 8-bit.
- R7: Register select: `bus_regsel` follows `bus_cs` for I/O codes (01x), dynamic sizing (001) and attribute memory (11x). It stays low for common memory (10x).
- R8: A request with attribute 000 raises `err` for exactly one cycle, starts no bus cycle and leaves `busy` low.
- R9: `done` pulses high for exactly one cycle. That cycle directly follows the last hold cycle, or the last strobe cycle when `H` is 0. It is the cycle after the accepting edge with index `S + B + X + H + 2`.
- R10: A read (`req_write`=0) drives only `bus_rd`, and `rd_data` takes the value `bus_din` had during the last strobe cycle. A write drives only `bus_wr`.
- R11: After reset every output is low. `bus_rd` and `bus_wr` are never high together, and neither is high without `bus_cs`.
- R12: A request presented while `busy` is high is ignored: it changes no timing and raises no `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 4×BASE_W | Base wait per slot, slot index {area, set} |
| cfg_xwait | input | 4×2 | Extra-wait code per slot |
| cfg_setup | input | 4×3 | Setup code per slot |
| cfg_hold | input | 4×3 | Hold code per slot |
| cfg_idle | input | 2×IDLE_W | Idle-gap cycles per area |
| req | input | 1 | Access request, sampled while not busy |
| req_area | input | 1 | Area of the access |
| req_tset | input | 1 | Timing-set bit of the access |
| req_attr | input | 3 | Space/width attribute |
| req_write | input | 1 | 1 = write, 0 = read |
| bus_din | input | DATA_W | Read data from the bus |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle end-of-access pulse |
| err | output | 1 | One-cycle reserved-attribute pulse |
| rd_data | output | DATA_W | Captured read data |
| bus_addr_vld | output | 1 | Address valid |
| bus_cs | output | 1 | Chip select |
| bus_ce_lo | output | 1 | Lower card enable |
| bus_ce_hi | output | 1 | Upper card enable |
| bus_regsel | output | 1 | Register-space select |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |

## Verification
The bench builds the block with its defaults: BASE_W = 4, IDLE_W = 3 and DATA_W = 16. With these values a 15-cycle base wait plus the 50-cycle extra code reaches the longest strobe, 66 cycles. That length exercises the top of the shared phase counter, and the 15-cycle setup and hold codes sit in the same range. Slot contents are randomized between accesses, so every setup, hold, extra-wait and idle code is exercised against every attribute. Directed runs cover the all-zero single-cycle access, the all-maximum access, reserved attributes, and requests injected while the sequencer is busy.

// File: rtl/lsbus_pkg.sv
package lsbus_pkg;

   localparam int NUM_AREA = 2;
   localparam int NUM_SET  = 2;
   localparam int NUM_SLOT = NUM_AREA * NUM_SET;
   localparam int XW_MAX   = 50;
   localparam int SH_W     = 4;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_GAP
   } phase_e;

   // setup / hold code to cycle count
   function automatic logic [SH_W-1:0] sh_cycles(input logic [2:0] code);
      logic [SH_W-1:0] r;
      case (code)
         3'd0:    r = 4'd0;
         3'd1:    r = 4'd1;
         3'd2:    r = 4'd2;
         3'd3:    r = 4'd3;
         3'd4:    r = 4'd4;
         3'd5:    r = 4'd6;
         3'd6:    r = 4'd8;
         default: r = 4'd15;
      endcase
      return r;
   endfunction

   // coarse extra-wait code to cycle count
   function automatic logic [5:0] xw_cycles(input logic [1:0] code);
      logic [5:0] r;
      case (code)
         2'd0:    r = 6'd0;
         2'd1:    r = 6'd15;
         2'd2:    r = 6'd30;
         default: r = 6'd50;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/lsbus_attr_dec.sv
module lsbus_attr_dec #(
   parameter bit DYN_WIDE = 1'b1
) (
   input  logic [2:0] attr,
   output logic       legal,
   output logic       wide,
   output logic       regsel
);
   logic dyn;

   assign dyn    = (attr == 3'b001);
   assign legal  = (attr != 3'b000);
   assign regsel = (attr[2:1] != 2'b10);

   generate
      if (DYN_WIDE) begin : g_dyn_wide
         assign wide = attr[0] | dyn;
      end else begin : g_dyn_narrow
         assign wide = attr[0] & ~dyn;
      end
   endgenerate

endmodule

// File: rtl/lsbus_param_sel.sv
module lsbus_param_sel
   import lsbus_pkg::*;
#(
   parameter int BASE_W = 4,
   parameter int IDLE_W = 3,
   parameter int CNT_W  = 7
) (
   input  logic [NUM_SLOT-1:0][BASE_W-1:0] cfg_base,
   input  logic [NUM_SLOT-1:0][1:0]        cfg_xwait,
   input  logic [NUM_SLOT-1:0][2:0]        cfg_setup,
   input  logic [NUM_SLOT-1:0][2:0]        cfg_hold,
   input  logic [NUM_AREA-1:0][IDLE_W-1:0] cfg_idle,
   input  logic                            area,
   input  logic                            tset,
   output logic [SH_W-1:0]                 setup_n,
   output logic [SH_W-1:0]                 hold_n,
   output logic [CNT_W-1:0]                wait_n,
   output logic [IDLE_W-1:0]               idle_n
);
   localparam int SLOT_W = $clog2(NUM_SLOT);

   logic [SLOT_W-1:0] slot;
   logic [CNT_W-1:0]  wait_tot [NUM_SLOT];
   logic [SH_W-1:0]   setup_tab [NUM_SLOT];
   logic [SH_W-1:0]   hold_tab [NUM_SLOT];

   assign slot = {area, tset};

   generate
      for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
         assign wait_tot[s]  = CNT_W'(cfg_base[s]) + CNT_W'(xw_cycles(cfg_xwait[s]));
         assign setup_tab[s] = sh_cycles(cfg_setup[s]);
         assign hold_tab[s]  = sh_cycles(cfg_hold[s]);
      end
   endgenerate

   assign wait_n  = wait_tot[slot];
   assign setup_n = setup_tab[slot];
   assign hold_n  = hold_tab[slot];
   assign idle_n  = cfg_idle[area];

endmodule

// File: rtl/lsbus_phase_fsm.sv
module lsbus_phase_fsm
   import lsbus_pkg::*;
#(
   parameter int IDLE_W = 3,
   parameter int CNT_W  = 7,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_write,
   input  logic              legal,
   input  logic              wide,
   input  logic              regsel,
   input  logic [SH_W-1:0]   setup_n,
   input  logic [SH_W-1:0]   hold_n,
   input  logic [CNT_W-1:0]  wait_n,
   input  logic [IDLE_W-1:0] idle_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rd_data,
   output logic              on_bus,
   output logic              ce_hi,
   output logic              regsel_o,
   output logic              rd,
   output logic              wr
);
   phase_e              ph;
   logic [CNT_W-1:0]    cnt;
   logic [SH_W-1:0]     hold_q;
   logic [IDLE_W-1:0]   idle_q;
   logic [CNT_W-1:0]    wait_q;
   logic                we_q;
   logic                wide_q;
   logic                regsel_q;
   logic                cnt_zero;

   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         cnt      <= '0;
         hold_q   <= '0;
         idle_q   <= '0;
         wait_q   <= '0;
         we_q     <= 1'b0;
         wide_q   <= 1'b0;
         regsel_q <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         rd_data  <= '0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (ph)
            PH_IDLE: begin
               if (req) begin
                  if (!legal) begin
                     err <= 1'b1;
                  end else begin
                     hold_q   <= hold_n;
                     idle_q   <= idle_n;
                     wait_q   <= wait_n;
                     we_q     <= req_write;
                     wide_q   <= wide;
                     regsel_q <= regsel;
                     if (setup_n != '0) begin
                        ph  <= PH_SETUP;
                        cnt <= CNT_W'(setup_n) - CNT_W'(1);
                     end else begin
                        ph  <= PH_STROBE;
                        cnt <= wait_n;
                     end
                  end
               end
            end
            PH_SETUP: begin
               if (cnt_zero) begin
                  ph  <= PH_STROBE;
                  cnt <= wait_q;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            PH_STROBE: begin
               if (cnt_zero) begin
                  if (!we_q) rd_data <= bus_din;
                  if (hold_q != '0) begin
                     ph  <= PH_HOLD;
                     cnt <= CNT_W'(hold_q) - CNT_W'(1);
                  end else begin
                     done <= 1'b1;
                     if (idle_q != '0) begin
                        ph  <= PH_GAP;
                        cnt <= CNT_W'(idle_q) - CNT_W'(1);
                     end else begin
                        ph <= PH_IDLE;
                     end
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            PH_HOLD: begin
               if (cnt_zero) begin
                  done <= 1'b1;
                  if (idle_q != '0) begin
                     ph  <= PH_GAP;
                     cnt <= CNT_W'(idle_q) - CNT_W'(1);
                  end else begin
                     ph <= PH_IDLE;
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            PH_GAP: begin
               if (cnt_zero) ph <= PH_IDLE;
               else          cnt <= cnt - CNT_W'(1);
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign busy     = (ph != PH_IDLE);
   assign on_bus   = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
   assign ce_hi    = on_bus & wide_q;
   assign regsel_o = on_bus & regsel_q;
   assign rd       = (ph == PH_STROBE) & ~we_q;
   assign wr       = (ph == PH_STROBE) &  we_q;

endmodule

// File: rtl/lsbus_cycle_ctrl.sv
module lsbus_cycle_ctrl
   import lsbus_pkg::*;
#(
   parameter int BASE_W   = 4,
   parameter int IDLE_W   = 3,
   parameter int DATA_W   = 16,
   parameter bit DYN_WIDE = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_SLOT-1:0][BASE_W-1:0] cfg_base,
   input  logic [NUM_SLOT-1:0][1:0]        cfg_xwait,
   input  logic [NUM_SLOT-1:0][2:0]        cfg_setup,
   input  logic [NUM_SLOT-1:0][2:0]        cfg_hold,
   input  logic [NUM_AREA-1:0][IDLE_W-1:0] cfg_idle,
   input  logic                            req,
   input  logic                            req_area,
   input  logic                            req_tset,
   input  logic [2:0]                      req_attr,
   input  logic                            req_write,
   input  logic [DATA_W-1:0]               bus_din,
   output logic                            busy,
   output logic                            done,
   output logic                            err,
   output logic [DATA_W-1:0]               rd_data,
   output logic                            bus_addr_vld,
   output logic                            bus_cs,
   output logic                            bus_ce_lo,
   output logic                            bus_ce_hi,
   output logic                            bus_regsel,
   output logic                            bus_rd,
   output logic                            bus_wr
);
   localparam int WAIT_MAX = (2 ** BASE_W) - 1 + XW_MAX;
   localparam int CNT_RAW  = $clog2(WAIT_MAX + 1);
   localparam int CNT_W    = (CNT_RAW > SH_W) ? CNT_RAW : SH_W;

   generate
      if (BASE_W < 1 || BASE_W > 8) begin : g_bad_base
         $error("lsbus_cycle_ctrl: BASE_W must be 1..8");
      end
      if (IDLE_W < 1 || IDLE_W > 8) begin : g_bad_idle
         $error("lsbus_cycle_ctrl: IDLE_W must be 1..8");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("lsbus_cycle_ctrl: DATA_W must be positive");
      end
   endgenerate

   logic              legal, wide, regsel;
   logic [SH_W-1:0]   setup_n, hold_n;
   logic [CNT_W-1:0]  wait_n;
   logic [IDLE_W-1:0] idle_n;
   logic              on_bus;

   lsbus_attr_dec #(.DYN_WIDE(DYN_WIDE)) u_dec (
      .attr   (req_attr),
      .legal  (legal),
      .wide   (wide),
      .regsel (regsel)
   );

   lsbus_param_sel #(.BASE_W(BASE_W), .IDLE_W(IDLE_W), .CNT_W(CNT_W)) u_sel (
      .cfg_base  (cfg_base),
      .cfg_xwait (cfg_xwait),
      .cfg_setup (cfg_setup),
      .cfg_hold  (cfg_hold),
      .cfg_idle  (cfg_idle),
      .area      (req_area),
      .tset      (req_tset),
      .setup_n   (setup_n),
      .hold_n    (hold_n),
      .wait_n    (wait_n),
      .idle_n    (idle_n)
   );

   lsbus_phase_fsm #(.IDLE_W(IDLE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .req_write (req_write),
      .legal     (legal),
      .wide      (wide),
      .regsel    (regsel),
      .setup_n   (setup_n),
      .hold_n    (hold_n),
      .wait_n    (wait_n),
      .idle_n    (idle_n),
      .bus_din   (bus_din),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .rd_data   (rd_data),
      .on_bus    (on_bus),
      .ce_hi     (bus_ce_hi),
      .regsel_o  (bus_regsel),
      .rd        (bus_rd),
      .wr        (bus_wr)
   );

   assign bus_addr_vld = on_bus;
   assign bus_cs       = on_bus;
   assign bus_ce_lo    = on_bus;

endmodule

// File: rtl/lsbus_cycle_ctrl_chk.sv
module lsbus_cycle_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req,
   input logic [2:0] req_attr,
   input logic       busy,
   input logic       done,
   input logic       err,
   input logic       bus_cs,
   input logic       bus_ce_hi,
   input logic       bus_regsel,
   input logic       bus_rd,
   input logic       bus_wr
);
   // R11: strobes exclusive
   a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   // R11: strobe only inside chip select
   a_r11_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> bus_cs);

   // R9: done lasts one cycle and comes with the bus released
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_cs);

   // R8: reserved attribute starts no cycle and reports
   a_r8_reserved_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy && req_attr == 3'b000) |=> (err && !bus_cs && !busy));

   // R7: register select follows the space of the accepted attribute
   a_r7_regsel_space: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_cs) |-> (bus_regsel == ($past(req_attr[2:1]) != 2'b10)));

   // R6: upper enable follows the width of the accepted attribute
   a_r6_ce_hi_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_cs) |-> (bus_ce_hi == ($past(req_attr[0]) || $past(req_attr[2:1]) == 2'b00)));

   // R12: bus activity is always covered by busy
   a_r12_busy_covers_bus: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs |-> busy);

endmodule

bind lsbus_cycle_ctrl lsbus_cycle_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req        (req),
   .req_attr   (req_attr),
   .busy       (busy),
   .done       (done),
   .err        (err),
   .bus_cs     (bus_cs),
   .bus_ce_hi  (bus_ce_hi),
   .bus_regsel (bus_regsel),
   .bus_rd     (bus_rd),
   .bus_wr     (bus_wr)
);

// File: tb/lsbus_cycle_ctrl_test.sv
module lsbus_cycle_ctrl_test;
   localparam int BASE_W = 4;
   localparam int IDLE_W = 3;
   localparam int DATA_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0][BASE_W-1:0] cfg_base = '0;
   logic [3:0][1:0]        cfg_xwait = '0;
   logic [3:0][2:0]        cfg_setup = '0;
   logic [3:0][2:0]        cfg_hold = '0;
   logic [1:0][IDLE_W-1:0] cfg_idle = '0;
   logic req = 1'b0, req_area = 1'b0, req_tset = 1'b0, req_write = 1'b0;
   logic [2:0] req_attr = 3'b0;
   logic [DATA_W-1:0] bus_din = '0;
   logic busy, done, err, bus_addr_vld, bus_cs, bus_ce_lo, bus_ce_hi;
   logic bus_regsel, bus_rd, bus_wr;
   logic [DATA_W-1:0] rd_data;

   int checks = 0;
   int fails = 0;

   always #4 clk = ~clk;

   lsbus_cycle_ctrl #(.BASE_W(BASE_W), .IDLE_W(IDLE_W), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_xwait(cfg_xwait),
      .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_idle(cfg_idle),
      .req(req), .req_area(req_area), .req_tset(req_tset), .req_attr(req_attr),
      .req_write(req_write), .bus_din(bus_din), .busy(busy), .done(done),
      .err(err), .rd_data(rd_data), .bus_addr_vld(bus_addr_vld), .bus_cs(bus_cs),
      .bus_ce_lo(bus_ce_lo), .bus_ce_hi(bus_ce_hi), .bus_regsel(bus_regsel),
      .bus_rd(bus_rd), .bus_wr(bus_wr));

   function automatic int exp_sh(input logic [2:0] c);
      case (c)
         3'd0: return 0;  3'd1: return 1;  3'd2: return 2;  3'd3: return 3;
         3'd4: return 4;  3'd5: return 6;  3'd6: return 8;  default: return 15;
      endcase
   endfunction

   function automatic int exp_xw(input logic [1:0] c);
      case (c)
         2'd0: return 0;  2'd1: return 15;  2'd2: return 30;  default: return 50;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic access(input logic a, input logic t, input logic [2:0] at,
                         input logic w, input bit inject);
      int idx, s, wt, h, i, total;
      int n_setup, n_strobe, n_hold, n_busy, n_done, done_j, n_err;
      int bad_ce, bad_rs, n_rd, n_wr;
      bit seen;
      logic exp_wide, exp_rs;
      logic [DATA_W-1:0] last_din;
      idx = a * 2 + t;
      s = exp_sh(cfg_setup[idx]);
      wt = int'(cfg_base[idx]) + exp_xw(cfg_xwait[idx]);
      h = exp_sh(cfg_hold[idx]);
      i = int'(cfg_idle[a]);
      total = s + wt + 1 + h + i;
      exp_wide = at[0] | (at[2:1] == 2'b00);
      exp_rs = (at[2:1] != 2'b10);
      n_setup = 0; n_strobe = 0; n_hold = 0; n_busy = 0; n_done = 0; done_j = 0;
      n_err = 0; bad_ce = 0; bad_rs = 0; n_rd = 0; n_wr = 0; seen = 0; last_din = '0;
      @(negedge clk);
      req = 1'b1; req_area = a; req_tset = t; req_attr = at; req_write = w;
      @(posedge clk);
      for (int j = 1; j < 400; j++) begin
         @(negedge clk);
         req = 1'b0;
         if (inject && j == 2 && total >= 3) begin
            req = 1'b1; req_attr = 3'b000;
         end
         bus_din = DATA_W'($urandom);
         if (bus_cs && !(bus_rd || bus_wr) && !seen) n_setup++;
         if (bus_rd || bus_wr) begin
            n_strobe++; seen = 1; last_din = bus_din;
         end
         if (bus_rd) n_rd++;
         if (bus_wr) n_wr++;
         if (bus_cs && !(bus_rd || bus_wr) && seen) n_hold++;
         if (bus_cs && (bus_ce_hi != exp_wide || !bus_ce_lo || !bus_addr_vld)) bad_ce++;
         if (bus_cs && bus_regsel != exp_rs) bad_rs++;
         if (done) begin n_done++; done_j = j; end
         if (err) n_err++;
         if (!busy) break;
         n_busy++;
      end
      req = 1'b0;
      check(n_setup == s, "R1 setup cycles", n_setup, s);
      check(n_strobe == wt + 1, "R2 strobe cycles", n_strobe, wt + 1);
      check(n_hold == h, "R3 hold cycles", n_hold, h);
      check(n_busy == total, "R5 busy cycles", n_busy, total);
      check(n_done == 1 && done_j == s + wt + h + 2, "R9 done position", done_j, s + wt + h + 2);
      check(bad_ce == 0, "R6 card enable width", bad_ce, 0);
      check(bad_rs == 0, "R7 register select", bad_rs, 0);
      check(n_err == 0, "R12 no error during access", n_err, 0);
      if (w) check(n_wr == wt + 1 && n_rd == 0, "R10 write strobe only", n_rd, 0);
      else begin
         check(n_rd == wt + 1 && n_wr == 0, "R10 read strobe only", n_wr, 0);
         check(rd_data == last_din, "R10 read capture", int'(rd_data), int'(last_din));
      end
   endtask

   task automatic reserved_req();
      @(negedge clk);
      req = 1'b1; req_attr = 3'b000; req_area = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      check(err == 1'b1, "R8 err pulse", int'(err), 1);
      check(!busy && !bus_cs, "R8 no bus cycle", int'(busy), 0);
      @(negedge clk);
      check(err == 1'b0 && !bus_cs, "R8 err single cycle", int'(err), 0);
   endtask

   task automatic randomize_cfg();
      for (int k = 0; k < 4; k++) begin
         cfg_base[k]  = BASE_W'($urandom);
         cfg_xwait[k] = 2'($urandom);
         cfg_setup[k] = 3'($urandom);
         cfg_hold[k]  = 3'($urandom);
      end
      cfg_idle[0] = IDLE_W'($urandom);
      cfg_idle[1] = IDLE_W'($urandom);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R11 reset state
      check({busy, done, err, bus_addr_vld, bus_cs, bus_ce_lo, bus_ce_hi,
             bus_regsel, bus_rd, bus_wr} == '0, "R11 reset outputs", 1, 0);
      check(rd_data == '0, "R11 reset read data", int'(rd_data), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // shortest access: everything zero
      access(1'b0, 1'b0, 3'b011, 1'b0, 1'b0);
      // longest access: all maxima
      cfg_base = '1; cfg_xwait = '1; cfg_setup = '1; cfg_hold = '1; cfg_idle = '1;
      access(1'b1, 1'b1, 3'b110, 1'b1, 1'b1);

      // R4: two sets of area 0 differ strongly
      cfg_base[0] = 4'd1; cfg_xwait[0] = 2'd0; cfg_setup[0] = 3'd1; cfg_hold[0] = 3'd0;
      cfg_base[1] = 4'd9; cfg_xwait[1] = 2'd2; cfg_setup[1] = 3'd6; cfg_hold[1] = 3'd5;
      cfg_idle[0] = 3'd2; cfg_idle[1] = 3'd6;
      access(1'b0, 1'b0, 3'b100, 1'b0, 1'b0);
      access(1'b0, 1'b1, 3'b100, 1'b0, 1'b0);
      // R5: same set index, other area picks area idle
      access(1'b1, 1'b0, 3'b001, 1'b1, 1'b0);

      reserved_req();
      // every attribute code once
      for (int c = 1; c < 8; c++) access(1'b0, c[0], 3'(c), c[1], 1'b1);

      for (int n = 0; n < 160; n++) begin
         if (n % 8 == 0) randomize_cfg();
         if (n % 23 == 5) reserved_req();
         access(1'($urandom), 1'($urandom), 3'(($urandom % 7) + 1), 1'($urandom),
                1'($urandom));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule